// File: doc/BRIEF.md
# Pointer-Addressed Parallel Control Register Port

This block gives an external host access to a bank of control registers over a narrow parallel bus. The host drives an active-low select, a read/write strobe, one address line and an 8-bit data bus that carries both register addresses and register data. With the address line low, the host reaches an internal address pointer. With it high, the host reaches the register that the pointer names. After every register access the pointer steps forward by one, so a run of registers can be filled or dumped without reloading the pointer. At the top register the pointer stops instead of wrapping.

All host inputs are asynchronous to the system clock. They pass through a two-flop synchronizer, and an access completes when the synchronized select returns high. The read path is registered and comes out as separate data and output-enable pins, which the pad ring turns into a tri-state bus. A synchronous reset returns the pointer and the synchronizers to idle and raises a power-down output, while the register contents are kept. A select input hands the register bank to another front end. While that input is low, the parallel port ignores all host activity.

The whole bank is also presented as one flat configuration vector for the logic the registers control.

Top module: `hostreg_port`

## Requirements
- R1: A write with `a0_i`=0 and `rw_i`=0 loads the pointer from `data_i[5:0]`. A read with `a0_i`=0 returns `{2'b00, pointer}` on `data_o`.
- R2: A write with `a0_i`=1 stores `data_i` into the register at the pointer. A read with `a0_i`=1 returns that register's contents on `data_o`.
- R3: Each completed register access (`a0_i`=1, read or write) advances the pointer by one. At 3Fh the pointer stays at 3Fh, so repeated writes there overwrite register 3Fh.
- R4: Pointer accesses (`a0_i`=0) never advance the pointer, and reading it leaves it unchanged.
- R5: `data_oe_o` is 1 only while the synchronized select is low with `rw_i`=1. Otherwise `data_oe_o` is 0 and `data_o` reads 00h.
- R6: While `par_sel_i` is 0, the port ignores the host. No register or pointer changes, and `data_oe_o` stays 0.
- R7: Reset clears the pointer to 0 and sets `pwr_down_o` to 1. Register contents are left unchanged.
- R8: A register write to address 00h sets `pwr_down_o` to the inverse of data bit 0. Writing 1 leaves power-down, and writing 0 re-enters it.
- R9: `cfg_o[8*i+7 : 8*i]` always shows the contents of register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_sel_i | input | 1 | 1: parallel port owns the bank; 0: port ignored |
| cs_n_i | input | 1 | Host select, active low; access completes on its rising edge |
| rw_i | input | 1 | 1 = read, 0 = write |
| a0_i | input | 1 | 0 = pointer, 1 = register at pointer |
| data_i | input | 8 | Host data bus, inbound |
| data_o | output | 8 | Host data bus, outbound (registered) |
| data_oe_o | output | 1 | Drive enable for the outbound bus |
| pwr_down_o | output | 1 | Power-down request |
| cfg_o | output | 512 | Flat view of all 64 registers |

## Verification
A register access and the pointer update it causes happen in the same clock. On a read, the completion edge also drops the output enable. The saturation case is where these events are hardest to separate: repeated writes at 3Fh must land on the same register while the pointer stays put. The bench provokes this by writing three values starting at 3Eh, then judges it by reading back both top registers and the pointer through the port. A write to register 00h changes the power-down output and advances the pointer in one cycle. The bench checks that the output changed and that a following pointer read shows 01h.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;

  // index and bit of the register that controls power-down
  localparam int PWR_REG = 0;
  localparam int PWR_BIT = 0;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_PTR_WR,
    ACC_PTR_RD,
    ACC_REG_WR,
    ACC_REG_RD
  } acc_e;

  function automatic acc_e acc_decode(input logic done, input logic a0, input logic rw);
    if (!done)   return ACC_IDLE;
    if (!a0)     return rw ? ACC_PTR_RD : ACC_PTR_WR;
    return rw ? ACC_REG_RD : ACC_REG_WR;
  endfunction

endpackage

// File: rtl/hostreg_sync.sv
module hostreg_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg_q[0] <= RST_VAL;
          else     stg_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg_q[s] <= RST_VAL;
          else     stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/hostreg_ptr.sv
module hostreg_ptr #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step_en,
  output logic [PTR_W-1:0] ptr_o
);

  localparam logic [PTR_W-1:0] PTR_MAX = '1;

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (load_en) begin
      ptr_q <= load_val;
    end else if (step_en && (ptr_q != PTR_MAX)) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/hostreg_bank.sv
module hostreg_bank #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic                               clk,
  input  logic                               wr_en,
  input  logic [PTR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [DATA_W-1:0]                  rd_data,
  output logic [(1<<PTR_W)*DATA_W-1:0]       cfg_o
);

  localparam int NREG = 1 << PTR_W;

  // contents survive reset by design: no reset branch
  logic [DATA_W-1:0] mem_q [NREG];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[addr] <= wr_data;
  end

  assign rd_data = mem_q[addr];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_flat
      assign cfg_o[i*DATA_W +: DATA_W] = mem_q[i];
    end
  endgenerate

endmodule

// File: rtl/hostreg_port.sv
module hostreg_port #(
  parameter int DATA_W      = 8,
  parameter int PTR_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         par_sel_i,
  input  logic                         cs_n_i,
  input  logic                         rw_i,
  input  logic                         a0_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [DATA_W-1:0]            data_o,
  output logic                         data_oe_o,
  output logic                         pwr_down_o,
  output logic [(1<<PTR_W)*DATA_W-1:0] cfg_o
);

  import hostreg_pkg::*;

  localparam int               SYNC_W   = DATA_W + 3;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {(SYNC_W-1){1'b0}}};
  localparam logic [PTR_W-1:0] PWR_ADDR = PTR_W'(PWR_REG);

  // synchronized host inputs
  logic [SYNC_W-1:0] sync_bus;
  logic              s_cs_n, s_rw, s_a0;
  logic [DATA_W-1:0] s_dat;

  hostreg_sync #(
    .W       (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({cs_n_i, rw_i, a0_i, data_i}),
    .sync_o  (sync_bus)
  );

  assign {s_cs_n, s_rw, s_a0, s_dat} = sync_bus;

  // one more stage: holds the values seen while select was still low
  logic              h_cs_n, h_rw, h_a0;
  logic [DATA_W-1:0] h_dat;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cs_n <= 1'b1;
      h_rw   <= 1'b0;
      h_a0   <= 1'b0;
      h_dat  <= '0;
    end else begin
      h_cs_n <= s_cs_n;
      h_rw   <= s_rw;
      h_a0   <= s_a0;
      h_dat  <= s_dat;
    end
  end

  logic cs_done;
  acc_e acc_kind;

  assign cs_done = par_sel_i && !h_cs_n && s_cs_n;

  always_comb acc_kind = acc_decode(cs_done, h_a0, h_rw);

  // pointer
  logic [PTR_W-1:0] ptr_q;
  logic             ptr_load, ptr_step, reg_wr;

  assign ptr_load = (acc_kind == ACC_PTR_WR);
  assign reg_wr   = (acc_kind == ACC_REG_WR);
  assign ptr_step = reg_wr || (acc_kind == ACC_REG_RD);

  hostreg_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load_en  (ptr_load),
    .load_val (h_dat[PTR_W-1:0]),
    .step_en  (ptr_step),
    .ptr_o    (ptr_q)
  );

  // register bank
  logic [DATA_W-1:0] bank_rd;

  hostreg_bank #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_bank (
    .clk     (clk),
    .wr_en   (reg_wr),
    .addr    (ptr_q),
    .wr_data (h_dat),
    .rd_data (bank_rd),
    .cfg_o   (cfg_o)
  );

  // power-down control
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_down_o <= 1'b1;
    end else if (reg_wr && (ptr_q == PWR_ADDR)) begin
      pwr_down_o <= !h_dat[PWR_BIT];
    end
  end

  // registered read path
  logic rd_act;
  assign rd_act = par_sel_i && !s_cs_n && s_rw;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe_o <= 1'b0;
      data_o    <= '0;
    end else begin
      data_oe_o <= rd_act;
      if (!rd_act)   data_o <= '0;
      else if (s_a0) data_o <= bank_rd;
      else           data_o <= DATA_W'(ptr_q);
    end
  end

endmodule

// File: rtl/hostreg_port_chk.sv
module hostreg_port_chk #(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             par_sel_i,
  input logic             data_oe_o,
  input logic             pwr_down_o,
  input logic             cs_done,
  input logic             acc_a0,
  input logic             acc_rw,
  input logic [PTR_W-1:0] acc_d,
  input logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] PTR_MAX = '1;

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cs_done && !acc_a0 && !acc_rw) |=> (ptr == $past(acc_d)));                     // R1

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (cs_done && acc_a0 && ptr != PTR_MAX) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));  // R3

  AST_PTR_SAT: assert property (@(posedge clk) disable iff (rst)
    (cs_done && acc_a0 && ptr == PTR_MAX) |=> (ptr == PTR_MAX));                    // R3

  AST_PTR_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cs_done && !acc_a0 && acc_rw) |=> $stable(ptr));                               // R4

  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cs_done |=> $stable(ptr));                                                     // R4

  AST_OE_OWNED: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> $past(par_sel_i));                                                // R6

  AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !par_sel_i |=> $stable(ptr));                                                   // R6

  AST_PD_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cs_done && acc_a0 && !acc_rw && ptr == '0) |=> (pwr_down_o == !$past(acc_d[0]))); // R8

  logic seen_q, rst_q;
  always_ff @(posedge clk) begin
    seen_q <= 1'b1;
    rst_q  <= rst;
  end

  always @(posedge clk) begin
    if (seen_q && rst_q) begin
      AST_RST_PD: assert (pwr_down_o && ptr == '0);                                 // R7
    end
  end

endmodule

bind hostreg_port hostreg_port_chk #(.PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .par_sel_i  (par_sel_i),
  .data_oe_o  (data_oe_o),
  .pwr_down_o (pwr_down_o),
  .cs_done    (cs_done),
  .acc_a0     (h_a0),
  .acc_rw     (h_rw),
  .acc_d      (h_dat[PTR_W-1:0]),
  .ptr        (ptr_q)
);

// File: tb/hostreg_port_tb_top.sv
module hostreg_port_tb_top;

  logic         clk = 1'b0;
  logic         rst;
  logic         par_sel_i;
  logic         cs_n_i;
  logic         rw_i;
  logic         a0_i;
  logic [7:0]   data_i;
  logic [7:0]   data_o;
  logic         data_oe_o;
  logic         pwr_down_o;
  logic [511:0] cfg_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hostreg_port dut_i (
    .clk        (clk),
    .rst        (rst),
    .par_sel_i  (par_sel_i),
    .cs_n_i     (cs_n_i),
    .rw_i       (rw_i),
    .a0_i       (a0_i),
    .data_i     (data_i),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o),
    .pwr_down_o (pwr_down_o),
    .cfg_o      (cfg_o)
  );

  // scoreboard: expected {oe, data} and the requirement tag
  logic [8:0] exp_q[$];
  string      tag_q[$];
  event       rd_ev;

  initial begin
    forever begin
      logic [8:0] e;
      string      t;
      @(rd_ev);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if ({data_oe_o, data_o} !== e) begin
        n_fail++;
        $display("FAIL %s: got oe=%b data=%h, exp oe=%b data=%h",
                 t, data_oe_o, data_o, e[8], e[7:0]);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", t, got, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    a0_i = a; rw_i = 1'b0; data_i = d; cs_n_i = 1'b0;
    cyc(4);
    cs_n_i = 1'b1;
    cyc(5);
    rw_i = 1'b1;
  endtask

  task automatic bus_rd(input logic a, input logic [7:0] exp, input string t);
    @(negedge clk);
    a0_i = a; rw_i = 1'b1; cs_n_i = 1'b0;
    cyc(5);
    exp_q.push_back({1'b1, exp}); tag_q.push_back(t);
    -> rd_ev;
    cs_n_i = 1'b1;
    cyc(5);
    exp_q.push_back(9'h000); tag_q.push_back({t, " R5 release"});
    -> rd_ev;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; par_sel_i = 1'b1; cs_n_i = 1'b1; rw_i = 1'b1; a0_i = 1'b0; data_i = 8'h00;
    cyc(4);
    rst = 1'b0;
    cyc(2);

    check("R7 reset pwr_down", 32'(pwr_down_o), 32'd1);
    check("R5 reset oe", 32'(data_oe_o), 32'd0);
    bus_rd(1'b0, 8'h00, "R7 pointer after reset");

    // R1 / R4 pointer load and read
    bus_wr(1'b0, 8'h15);
    bus_rd(1'b0, 8'h15, "R1 pointer readback");
    bus_rd(1'b0, 8'h15, "R4 pointer read no step");
    bus_wr(1'b0, 8'hFF);
    bus_rd(1'b0, 8'h3F, "R1 upper bits zero");

    // R2 / R3 burst write and readback
    bus_wr(1'b0, 8'h10);
    bus_wr(1'b1, 8'hA5);
    bus_wr(1'b1, 8'h5A);
    bus_wr(1'b1, 8'hC3);
    bus_rd(1'b0, 8'h13, "R3 step after writes");
    bus_wr(1'b0, 8'h10);
    bus_rd(1'b1, 8'hA5, "R2 read reg10");
    bus_rd(1'b1, 8'h5A, "R2 read reg11");
    bus_rd(1'b1, 8'hC3, "R2 read reg12");
    bus_rd(1'b0, 8'h13, "R3 step after reads");
    check("R9 cfg reg10", 32'(cfg_o[8*16 +: 8]), 32'hA5);
    check("R9 cfg reg12", 32'(cfg_o[8*18 +: 8]), 32'hC3);

    // R3 saturation at the top register
    bus_wr(1'b0, 8'h3E);
    bus_wr(1'b1, 8'h11);
    bus_wr(1'b1, 8'h22);
    bus_wr(1'b1, 8'h33);
    bus_rd(1'b0, 8'h3F, "R3 pointer saturated");
    bus_wr(1'b0, 8'h3E);
    bus_rd(1'b1, 8'h11, "R3 reg3E");
    bus_rd(1'b1, 8'h33, "R3 reg3F last write");
    bus_rd(1'b1, 8'h33, "R3 reg3F repeat read");
    bus_rd(1'b0, 8'h3F, "R3 pointer still 3F");
    check("R9 cfg reg3F", 32'(cfg_o[8*63 +: 8]), 32'h33);

    // R6 port deselected
    bus_wr(1'b0, 8'h10);
    par_sel_i = 1'b0;
    bus_wr(1'b1, 8'hEE);
    bus_wr(1'b0, 8'h05);
    @(negedge clk);
    a0_i = 1'b1; rw_i = 1'b1; cs_n_i = 1'b0;
    cyc(5);
    check("R6 oe while deselected", 32'(data_oe_o), 32'd0);
    cs_n_i = 1'b1;
    cyc(5);
    par_sel_i = 1'b1;
    cyc(2);
    bus_rd(1'b0, 8'h10, "R6 pointer untouched");
    bus_rd(1'b1, 8'hA5, "R6 register untouched");

    // R8 power-down control via register 00h
    bus_wr(1'b0, 8'h00);
    bus_wr(1'b1, 8'h01);
    check("R8 pwr cleared", 32'(pwr_down_o), 32'd0);
    bus_rd(1'b0, 8'h01, "R3 step after reg00 write");
    bus_wr(1'b0, 8'h00);
    bus_wr(1'b1, 8'h00);
    check("R8 pwr set by zero", 32'(pwr_down_o), 32'd1);
    bus_wr(1'b0, 8'h00);
    bus_wr(1'b1, 8'h03);
    check("R8 pwr cleared again", 32'(pwr_down_o), 32'd0);

    // R7 reset keeps contents
    bus_wr(1'b0, 8'h20);
    @(negedge clk);
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(3);
    check("R7 pwr after reset", 32'(pwr_down_o), 32'd1);
    bus_rd(1'b0, 8'h00, "R7 pointer cleared");
    bus_rd(1'b1, 8'h03, "R7 reg00 retained");
    bus_wr(1'b0, 8'h10);
    bus_rd(1'b1, 8'hA5, "R7 reg10 retained");
    check("R9 cfg reg00 retained", 32'(cfg_o[7:0]), 32'h03);

    cyc(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule